// File: doc/BRIEF.md
# Thresholded Transmit/Receive Word FIFO Pair

This block sits between a register-mapped host port and a serial shift engine. It holds outgoing and incoming 32-bit words in two small FIFOs. Byte lane n of a word occupies bits 8n+7:8n, so the lowest byte is the first byte on the wire. Each FIFO reports its fill state with full, empty, sticky overflow and sticky underflow flags. A separate ready flag compares the occupancy, counted in bytes, against a 3-bit threshold. A one-shot flush command empties both FIFOs. The flush flag stays up while the flush is in progress and then drops by itself.

The host side uses plain strobes. `host_tx_push` writes a word into the transmit FIFO. `host_rx_pop` takes the oldest received word into the `host_rx_data` register, and that register holds its value until the next successful pop.

The engine side is a valid/ready stream with no waiting allowed. The block drives `eng_tx_valid` whenever it holds a word, and a word leaves on any cycle where `eng_tx_ready` is high. The engine must not assert `eng_tx_ready` to wait for data. If it asserts it while the FIFO is empty, that cycle is a starved slot and is recorded as an underflow. The block drives `eng_rx_ready` while it has room. If the engine offers a word with `eng_rx_valid` while `eng_rx_ready` is low, that word is lost. It is recorded as an overflow when the FIFO is full, and dropped silently during a flush.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset both FIFOs are empty and not full, all four sticky flags are 0, `flush_busy` is 0, `host_rx_data` is 0 and `eng_tx_valid` is 0.
- R2: Words written with `host_tx_push` leave on `eng_tx_data` in the order written. `eng_tx_valid` is high exactly when the transmit FIFO holds a word and no flush is in progress. `tx_empty` and `tx_full` follow the word count one cycle after each push or pop edge.
- R3: A `host_tx_push` while the transmit FIFO is full is dropped and sets `tx_overflow`. The flag stays set until a flush or reset.
- R4: `eng_tx_ready` asserted while the transmit FIFO is empty sets `tx_underflow`, which is sticky until flush or reset. The FIFO contents are not changed.
- R5: A word offered with `eng_rx_valid` while `eng_rx_ready` is high is stored. `eng_rx_ready` is high exactly when the receive FIFO is not full and no flush is in progress. A `host_rx_pop` on a non-empty FIFO loads the oldest word into `host_rx_data` one cycle later.
- R6: A word offered with `eng_rx_valid` while the receive FIFO is full is dropped and sets `rx_overflow`, which is sticky until flush or reset.
- R7: A `host_rx_pop` on an empty receive FIFO sets `rx_underflow`, which is sticky until flush or reset, and leaves `host_rx_data` at its previous value.
- R8: `rx_ready` is high exactly when 4 × (words held) > `rx_thresh`.
- R9: `tx_ready` is high exactly when 4 × (free word slots) > `tx_thresh`. With a threshold of 3 it signals room for one more word.
- R10: A `flush_req` sampled high makes `flush_busy` high in the next cycle. While busy, every push and pop is ignored and sets no flag. At the end of the busy cycle both FIFOs are empty, all four sticky flags are clear, and `flush_busy` returns to 0 unless `flush_req` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_thresh | input | 3 | Transmit ready threshold in bytes |
| rx_thresh | input | 3 | Receive ready threshold in bytes |
| flush_req | input | 1 | Request to empty both FIFOs |
| flush_busy | output | 1 | Flush in progress, clears itself |
| host_tx_push | input | 1 | Host write strobe into transmit FIFO |
| host_tx_data | input | 32 | Host write word |
| host_rx_pop | input | 1 | Host read strobe from receive FIFO |
| host_rx_data | output | 32 | Last word popped by the host |
| eng_tx_valid | output | 1 | Transmit word available to engine |
| eng_tx_ready | input | 1 | Engine takes a transmit word |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_rx_valid | input | 1 | Engine offers a received word |
| eng_rx_ready | output | 1 | Receive FIFO can accept a word |
| eng_rx_data | input | 32 | Received word from engine |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_overflow | output | 1 | Sticky transmit overflow |
| tx_underflow | output | 1 | Sticky transmit underflow |
| tx_ready | output | 1 | Transmit free space exceeds threshold |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_overflow | output | 1 | Sticky receive overflow |
| rx_underflow | output | 1 | Sticky receive underflow |
| rx_ready | output | 1 | Receive occupancy exceeds threshold |

## Verification
The hardest case to reach from the ports is traffic that arrives during the single cycle in which `flush_busy` is high. Pushes, pops and starved engine requests in that cycle must leave no trace. The same holds for a push and a pop in the same cycle against a full or an empty FIFO, where the outcome depends on the occupancy before the edge.

The stimulus reaches these cases in two ways. Directed sequences place every kind of strobe exactly in the busy cycle and in the full and empty corners. A long random phase with frequent flush requests and heavy strobe rates then crosses them with every occupancy level and every threshold value. A queue-based model checks every output on every cycle.

// File: rtl/spi_fifo_pair_pkg.sv
package spi_fifo_pair_pkg;
  parameter int WORD_W = 32;
  parameter int BYTES_PER_WORD = WORD_W / 8;
  parameter int THR_W = 3;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [THR_W-1:0] thr_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             pop_ack,
  output logic             ovf,
  output logic             unf
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ack;

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign push_ack = push && !full && !flush;
  assign pop_ack  = pop && !empty && !flush;
  assign head_data = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ack) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      if (push_ack) wr_ptr <= nxt(wr_ptr);
      if (pop_ack)  rd_ptr <= nxt(rd_ptr);
      count <= count + CNT_W'(push_ack) - CNT_W'(pop_ack);
      if (push && full) ovf <= 1'b1;
      if (pop && empty) unf <= 1'b1;
    end
  end

  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && full && push && !pop) |=> (full && ovf)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flush) |=> ovf); // R3
  AST_EMPTY_POP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && empty && pop && !push) |=> (empty && unf)); // R4
  AST_FLUSH_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !ovf && !unf)); // R10
endmodule

// File: rtl/spi_fill_flag.sv
module spi_fill_flag #(
  parameter int DEPTH = 2,
  parameter int BPW = 4,
  parameter int THR_W = 3,
  parameter bit COUNT_FREE = 1'b0,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BYTE_W = $clog2(DEPTH * BPW + 1),
  localparam int CMP_W = (BYTE_W > THR_W) ? BYTE_W : THR_W
) (
  input  logic [CNT_W-1:0] count,
  input  logic [THR_W-1:0] thr,
  output logic             rdy
);
  logic [CMP_W-1:0] bytes;

  generate
    if (COUNT_FREE) begin : g_free
      assign bytes = CMP_W'(DEPTH * BPW) - CMP_W'(count) * CMP_W'(BPW);
    end else begin : g_held
      assign bytes = CMP_W'(count) * CMP_W'(BPW);
    end
  endgenerate

  assign rdy = (bytes > CMP_W'(thr));
endmodule

// File: rtl/spi_flush_ctrl.sv
module spi_flush_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_req,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= flush_req;
  end

  AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !flush_req) |=> !busy); // R10
  AST_FLUSH_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> busy); // R10
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pair_pkg::*;
#(
  parameter int TX_DEPTH = 2,
  parameter int RX_DEPTH = 2,
  localparam int TX_CNT_W = $clog2(TX_DEPTH + 1),
  localparam int RX_CNT_W = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [THR_W-1:0]  tx_thresh,
  input  logic [THR_W-1:0]  rx_thresh,
  input  logic              flush_req,
  output logic              flush_busy,
  input  logic              host_tx_push,
  input  logic [WORD_W-1:0] host_tx_data,
  input  logic              host_rx_pop,
  output logic [WORD_W-1:0] host_rx_data,
  output logic              eng_tx_valid,
  input  logic              eng_tx_ready,
  output logic [WORD_W-1:0] eng_tx_data,
  input  logic              eng_rx_valid,
  output logic              eng_rx_ready,
  input  logic [WORD_W-1:0] eng_rx_data,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_overflow,
  output logic              tx_underflow,
  output logic              tx_ready,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_overflow,
  output logic              rx_underflow,
  output logic              rx_ready
);
  logic [TX_CNT_W-1:0] tx_count;
  logic [RX_CNT_W-1:0] rx_count;
  logic                tx_pop_ack, rx_pop_ack;
  word_t               rx_head;

  spi_flush_ctrl u_flush (
    .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .busy(flush_busy)
  );

  spi_word_fifo #(.DEPTH(TX_DEPTH), .WIDTH(WORD_W)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush_busy),
    .push(host_tx_push), .push_data(host_tx_data),
    .pop(eng_tx_ready), .head_data(eng_tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty),
    .pop_ack(tx_pop_ack), .ovf(tx_overflow), .unf(tx_underflow)
  );

  spi_word_fifo #(.DEPTH(RX_DEPTH), .WIDTH(WORD_W)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush_busy),
    .push(eng_rx_valid), .push_data(eng_rx_data),
    .pop(host_rx_pop), .head_data(rx_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty),
    .pop_ack(rx_pop_ack), .ovf(rx_overflow), .unf(rx_underflow)
  );

  spi_fill_flag #(.DEPTH(TX_DEPTH), .BPW(BYTES_PER_WORD), .THR_W(THR_W),
                  .COUNT_FREE(1'b1)) u_tx_flag (
    .count(tx_count), .thr(tx_thresh), .rdy(tx_ready)
  );

  spi_fill_flag #(.DEPTH(RX_DEPTH), .BPW(BYTES_PER_WORD), .THR_W(THR_W),
                  .COUNT_FREE(1'b0)) u_rx_flag (
    .count(rx_count), .thr(rx_thresh), .rdy(rx_ready)
  );

  assign eng_tx_valid = !tx_empty && !flush_busy;
  assign eng_rx_ready = !rx_full && !flush_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          host_rx_data <= '0;
    else if (rx_pop_ack) host_rx_data <= rx_head;
  end

  AST_RX_DATA_HOLD_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rx_pop && rx_empty) |=> $stable(host_rx_data)); // R7
  AST_TX_TAKE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_valid && eng_tx_ready && !host_tx_push) |=> !tx_full); // R2
endmodule

// File: tb/test_spi_fifo_pair.sv
module test_spi_fifo_pair;
  localparam int TXD = 2;
  localparam int RXD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tx_thresh = 3'd3, rx_thresh = 3'd3;
  logic        flush_req = 1'b0;
  logic        flush_busy;
  logic        host_tx_push = 1'b0;
  logic [31:0] host_tx_data = '0;
  logic        host_rx_pop = 1'b0;
  logic [31:0] host_rx_data;
  logic        eng_tx_valid, eng_tx_ready = 1'b0;
  logic [31:0] eng_tx_data;
  logic        eng_rx_valid = 1'b0, eng_rx_ready;
  logic [31:0] eng_rx_data = '0;
  logic        tx_full, tx_empty, tx_overflow, tx_underflow, tx_ready;
  logic        rx_full, rx_empty, rx_overflow, rx_underflow, rx_ready;

  int vectors = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spi_fifo_pair #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) i_spi_fifo_pair (
    .clk(clk), .rst_n(rst_n), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .flush_req(flush_req), .flush_busy(flush_busy),
    .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
    .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
    .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data),
    .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready), .eng_rx_data(eng_rx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_overflow(tx_overflow),
    .tx_underflow(tx_underflow), .tx_ready(tx_ready),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_overflow(rx_overflow),
    .rx_underflow(rx_underflow), .rx_ready(rx_ready)
  );

  // behavioural reference model
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  bit m_tovf, m_tunf, m_rovf, m_runf, m_busy;
  logic [31:0] m_rdata = '0;

  always @(posedge clk) begin
    bit tf, te, rf, re;
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_tovf = 0; m_tunf = 0; m_rovf = 0; m_runf = 0; m_busy = 0; m_rdata = '0;
    end else begin
      if (m_busy) begin
        txq.delete(); rxq.delete();
        m_tovf = 0; m_tunf = 0; m_rovf = 0; m_runf = 0;
      end else begin
        tf = (txq.size() == TXD); te = (txq.size() == 0);
        rf = (rxq.size() == RXD); re = (rxq.size() == 0);
        if (host_tx_push && tf) m_tovf = 1;
        if (eng_tx_ready && te) m_tunf = 1;
        if (eng_tx_ready && !te) void'(txq.pop_front());
        if (host_tx_push && !tf) txq.push_back(host_tx_data);
        if (eng_rx_valid && rf) m_rovf = 1;
        if (host_rx_pop && re) m_runf = 1;
        if (host_rx_pop && !re) m_rdata = rxq.pop_front();
        if (eng_rx_valid && !rf) rxq.push_back(eng_rx_data);
      end
      m_busy = flush_req;
    end
  end

  task automatic chk(input string tag, input string name,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, name, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2", "tx_empty", tx_empty, txq.size() == 0);
    chk("R2", "tx_full", tx_full, txq.size() == TXD);
    chk("R2", "eng_tx_valid", eng_tx_valid, (txq.size() > 0) && !m_busy);
    if (txq.size() > 0) chk("R2", "eng_tx_data", eng_tx_data, txq[0]);
    chk("R3", "tx_overflow", tx_overflow, m_tovf);
    chk("R4", "tx_underflow", tx_underflow, m_tunf);
    chk("R5", "rx_empty", rx_empty, rxq.size() == 0);
    chk("R5", "rx_full", rx_full, rxq.size() == RXD);
    chk("R5", "eng_rx_ready", eng_rx_ready, (rxq.size() < RXD) && !m_busy);
    chk("R5", "host_rx_data", host_rx_data, m_rdata);
    chk("R6", "rx_overflow", rx_overflow, m_rovf);
    chk("R7", "rx_underflow", rx_underflow, m_runf);
    chk("R8", "rx_ready", rx_ready, (4 * rxq.size()) > int'(rx_thresh));
    chk("R9", "tx_ready", tx_ready, (4 * (TXD - txq.size())) > int'(tx_thresh));
    chk("R10", "flush_busy", flush_busy, m_busy);
  endtask

  // one cycle: compare at falling edge, then apply inputs for the next rising edge
  task automatic cyc(input bit tp, input bit er, input bit rv, input bit rp, input bit fl);
    @(negedge clk);
    compare_all();
    host_tx_push = tp; host_tx_data = $urandom;
    eng_tx_ready = er;
    eng_rx_valid = rv; eng_rx_data = $urandom;
    host_rx_pop = rp;
    flush_req = fl;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state against constants
    chk("R1", "tx_empty", tx_empty, 1);
    chk("R1", "tx_full", tx_full, 0);
    chk("R1", "rx_empty", rx_empty, 1);
    chk("R1", "rx_full", rx_full, 0);
    chk("R1", "sticky", {tx_overflow, tx_underflow, rx_overflow, rx_underflow}, 0);
    chk("R1", "flush_busy", flush_busy, 0);
    chk("R1", "host_rx_data", host_rx_data, 0);
    chk("R1", "eng_tx_valid", eng_tx_valid, 0);

    // R2 R3: fill transmit FIFO, overflow push, simultaneous push and take when full
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0);
    // R4: starved engine slots, then push and take on empty
    cyc(0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0); cyc(1, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    // R6 R7: fill receive FIFO past full, pop past empty, data holds last value
    cyc(0, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 1, 0); cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0);
    // R10: flush with every strobe landing in the busy cycle
    cyc(1, 0, 1, 0, 0); cyc(1, 0, 0, 0, 1);
    cyc(1, 1, 1, 1, 0); cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    // R10: held request keeps flush busy
    cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); cyc(1, 0, 1, 0, 0); cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
    // R8 R9: threshold sweep at each occupancy
    for (int occ = 0; occ <= 2; occ++) begin
      for (int t = 0; t < 8; t++) begin
        @(negedge clk);
        tx_thresh = 3'(t); rx_thresh = 3'(7 - t);
        cyc(0, 0, 0, 0, 0);
      end
      cyc(1, 0, 1, 0, 0);
    end
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0);
    // random phase mixing all strobes, thresholds and flushes
    for (int i = 0; i < 4000; i++) begin
      if (i % 37 == 0) begin
        @(negedge clk);
        tx_thresh = 3'($urandom); rx_thresh = 3'($urandom);
      end
      cyc(($urandom % 100) < 45, ($urandom % 100) < 40, ($urandom % 100) < 45,
          ($urandom % 100) < 40, ($urandom % 100) < 4);
    end
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    compare_all();
    finish_run();
  end
endmodule